// File: doc/BRIEF.md
# Post-Multiplier Arithmetic/Logic Stage

This block is the stage that follows the multiplier inside a DSP slice. It takes two 56-bit operands, X and Y, and a carry input. It applies one of sixteen encoded operations: six arithmetic and ten bitwise. Before the operation it can exchange the two operands. An arithmetic result can be checked against a programmable bit rank, which raises an overflow flag and can clamp the value to the nearest bound of that rank. The opcode comes from a static configuration input or, per cycle, from a 6-bit data input.

The result and its flags are captured in output registers. One single-bit select picks which of two internal carry taps is presented as the carry output. The Z register has its own synchronous reset. A second synchronous reset clears the flag registers. A write enable, when low, freezes every register. The block has no state machine: each cycle's output depends only on the inputs at the preceding edge and on the register contents.

Top module: `dsp_post_alu`

## Requirements
- R1: Arithmetic opcodes act on the 56-bit result Z as follows: 000000 gives Y+X, 000001 gives Y+X+CI, 001010 gives Y−X, 001011 gives Y−X−CI, 000101 gives Y+CI and 000111 gives Y−CI. Without saturation, Z is the low 56 bits of the exact result.
- R2: Bitwise opcodes act as follows: 100000 gives Y, 110000 gives ~Y, 100001 gives Y&X, 101001 gives Y&~X, 110001 gives ~(Y&X), 100010 gives Y|X, 101010 gives Y|~X, 110010 gives ~(Y|X), 100011 gives Y^X and 110011 gives ~(Y^X). These opcodes never raise overflow and never drive the carry output.
- R3: Any of the other 48 opcode values loads Z with zero and sets the invalid flag in the same cycle, with overflow and carry both 0.
- R4: When the swap input is 1, X and Y exchange roles before the operation.
- R5: When the dynamic-source input is 1, the opcode is taken from the 6-bit data input and the static opcode has no effect. When it is 0, the data input has no effect.
- R6: When co_sel is 0, the carry output is the carry out of the low 37 bits. When co_sel is 1, it is the carry out of the low 49 bits. Both carries come from the adder form Y+B+c, where B is X, ~X, 0 or all ones and c is 0, 1, CI or ~CI, as each operation needs. Subtraction therefore reports 1 for "no borrow".
- R7: For arithmetic opcodes, overflow is 1 when the exact result lies outside the range set by the rank r. The signed range is −2^(r−1)..2^(r−1)−1 and the unsigned range is 0..2^r−1. Operands are sign-extended in signed mode and zero-extended in unsigned mode. A rank above 55 acts as 55, and a rank of 0 acts as 1.
- R8: With saturation enabled and overflow raised, Z equals the violated bound (upper or lower), written as a 56-bit two's-complement value.
- R9: With saturation disabled, overflow is still reported, and Z keeps the wrapped low 56 bits.
- R10: All outputs are registered with one cycle of latency. While the write enable is 0, Z and all flags hold their values.
- R11: rst_z clears only Z, and rst_pipe clears only the overflow, carry and invalid flags. Both act at the rising edge and take priority over the write enable.
- R12: After both resets have been held for one edge, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_pipe | input | 1 | Synchronous reset of flag registers |
| rst_z | input | 1 | Synchronous reset of the Z register |
| wr_en | input | 1 | Register update enable; 0 freezes everything |
| y_in | input | 56 | Operand Y |
| x_in | input | 56 | Operand X |
| cin | input | 1 | Carry input |
| d_op | input | 6 | Per-cycle opcode source |
| cfg_op | input | 6 | Static opcode |
| cfg_dyn | input | 1 | 1 selects d_op as opcode |
| cfg_swap | input | 1 | 1 exchanges X and Y |
| cfg_signed | input | 1 | 1 selects signed range and sign extension |
| cfg_sat | input | 1 | 1 enables clamping on overflow |
| cfg_rank | input | 6 | MSB rank of the checked range |
| cfg_co_sel | input | 1 | 0 selects the 37-bit carry, 1 the 49-bit carry |
| z_out | output | 56 | Registered result |
| ovf_out | output | 1 | Registered overflow flag |
| co_out | output | 1 | Registered carry output |
| inv_out | output | 1 | Registered invalid-opcode flag |

## Verification
The only state is one register stage, so a wrong decode, carry tap or bound appears at z_out or a flag one edge after the operands are presented. While wr_en is low, an error captured earlier persists unchanged at the ports. The reference model computes exact results as 64-bit integers and compares all four outputs after every edge. A mis-decoded opcode, a wrong rank bound or a misrouted reset therefore shows up within one cycle. Random vectors mix every opcode, both signedness modes, all 64 rank codes, freezes and partial resets.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        K_ADD, K_ADDC, K_SUB, K_SUBC, K_INCY, K_DECY,
        K_PASSY, K_NOTY, K_AND, K_ANDN, K_NAND, K_OR, K_ORN, K_NOR, K_XOR, K_XNOR
    } alu_kind_e;

    typedef struct packed {
        alu_kind_e kind;
        logic      valid;
        logic      arith;
    } alu_dec_t;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import alu_pkg::*;
#(
    parameter int OPW = 6
) (
    input  logic [OPW-1:0] code,
    output alu_dec_t       dec
);
    always_comb begin
        dec = '{kind: K_ADD, valid: 1'b1, arith: 1'b1};
        case (code)
            6'b000000: dec.kind = K_ADD;
            6'b000001: dec.kind = K_ADDC;
            6'b001010: dec.kind = K_SUB;
            6'b001011: dec.kind = K_SUBC;
            6'b000101: dec.kind = K_INCY;
            6'b000111: dec.kind = K_DECY;
            6'b100000: begin dec.kind = K_PASSY; dec.arith = 1'b0; end
            6'b110000: begin dec.kind = K_NOTY;  dec.arith = 1'b0; end
            6'b100001: begin dec.kind = K_AND;   dec.arith = 1'b0; end
            6'b101001: begin dec.kind = K_ANDN;  dec.arith = 1'b0; end
            6'b110001: begin dec.kind = K_NAND;  dec.arith = 1'b0; end
            6'b100010: begin dec.kind = K_OR;    dec.arith = 1'b0; end
            6'b101010: begin dec.kind = K_ORN;   dec.arith = 1'b0; end
            6'b110010: begin dec.kind = K_NOR;   dec.arith = 1'b0; end
            6'b100011: begin dec.kind = K_XOR;   dec.arith = 1'b0; end
            6'b110011: begin dec.kind = K_XNOR;  dec.arith = 1'b0; end
            default:   begin dec.valid = 1'b0;   dec.arith = 1'b0; end
        endcase
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int W     = 56,
    parameter int CO_LO = 37,
    parameter int CO_HI = 49
) (
    input  alu_dec_t     dec,
    input  logic [W-1:0] opy,
    input  logic [W-1:0] opx,
    input  logic         cin,
    input  logic         sgn,
    output logic [W+1:0] wide,
    output logic [W-1:0] lres,
    output logic         c_lo,
    output logic         c_hi
);
    localparam int EW = W + 2;

    logic [EW-1:0]    ey, ex, ec;
    logic [CO_HI-1:0] badd;
    logic             bcin;
    logic [CO_LO:0]   s_lo;
    logic [CO_HI:0]   s_hi;

    assign ey = sgn ? {{2{opy[W-1]}}, opy} : {2'b00, opy};
    assign ex = sgn ? {{2{opx[W-1]}}, opx} : {2'b00, opx};
    assign ec = {{(EW-1){1'b0}}, cin};

    always_comb begin
        wide = '0;
        lres = '0;
        badd = '0;
        bcin = 1'b0;
        unique case (dec.kind)
            K_ADD:   begin wide = ey + ex;      badd = opx[CO_HI-1:0];  end
            K_ADDC:  begin wide = ey + ex + ec; badd = opx[CO_HI-1:0];  bcin = cin;  end
            K_SUB:   begin wide = ey - ex;      badd = ~opx[CO_HI-1:0]; bcin = 1'b1; end
            K_SUBC:  begin wide = ey - ex - ec; badd = ~opx[CO_HI-1:0]; bcin = ~cin; end
            K_INCY:  begin wide = ey + ec;      bcin = cin;  end
            K_DECY:  begin wide = ey - ec;      badd = '1;   bcin = ~cin; end
            K_PASSY: lres = opy;
            K_NOTY:  lres = ~opy;
            K_AND:   lres = opy & opx;
            K_ANDN:  lres = opy & ~opx;
            K_NAND:  lres = ~(opy & opx);
            K_OR:    lres = opy | opx;
            K_ORN:   lres = opy | ~opx;
            K_NOR:   lres = ~(opy | opx);
            K_XOR:   lres = opy ^ opx;
            K_XNOR:  lres = ~(opy ^ opx);
        endcase
    end

    assign s_lo = {1'b0, opy[CO_LO-1:0]} + {1'b0, badd[CO_LO-1:0]} + {{CO_LO{1'b0}}, bcin};
    assign s_hi = {1'b0, opy[CO_HI-1:0]} + {1'b0, badd} + {{CO_HI{1'b0}}, bcin};

    assign c_lo = dec.valid & dec.arith & s_lo[CO_LO];
    assign c_hi = dec.valid & dec.arith & s_hi[CO_HI];
endmodule

// File: rtl/alu_sat.sv
module alu_sat #(
    parameter int W  = 56,
    parameter int RW = $clog2(W)
) (
    input  logic [W+1:0]  wide,
    input  logic [W-1:0]  lres,
    input  logic          valid,
    input  logic          arith,
    input  logic          sat_en,
    input  logic          sgn,
    input  logic [RW-1:0] rank,
    output logic [W-1:0]  z_next,
    output logic          ovf_next
);
    localparam int EW   = W + 2;
    localparam int RMAX = W - 1;

    logic [RW-1:0] r;
    logic [EW-1:0] hi, lo;
    logic          over, under;

    always_comb begin
        if (rank > RW'(RMAX))    r = RW'(RMAX);
        else if (rank == '0)     r = RW'(1);
        else                     r = rank;
        if (sgn) begin
            hi = (EW'(1) << (r - RW'(1))) - EW'(1);
            lo = '0 - (EW'(1) << (r - RW'(1)));
        end else begin
            hi = (EW'(1) << r) - EW'(1);
            lo = '0;
        end
    end

    assign over     = $signed(wide) > $signed(hi);
    assign under    = $signed(wide) < $signed(lo);
    assign ovf_next = valid & arith & (over | under);

    always_comb begin
        if (!valid)                 z_next = '0;
        else if (!arith)            z_next = lres;
        else if (sat_en && over)    z_next = hi[W-1:0];
        else if (sat_en && under)   z_next = lo[W-1:0];
        else                        z_next = wide[W-1:0];
    end
endmodule

// File: rtl/dsp_post_alu.sv
module dsp_post_alu
    import alu_pkg::*;
#(
    parameter int W     = 56,
    parameter int OPW   = 6,
    parameter int CO_LO = 37,
    parameter int CO_HI = 49
) (
    input  logic           clk,
    input  logic           rst_pipe,
    input  logic           rst_z,
    input  logic           wr_en,
    input  logic [W-1:0]   y_in,
    input  logic [W-1:0]   x_in,
    input  logic           cin,
    input  logic [OPW-1:0] d_op,
    input  logic [OPW-1:0] cfg_op,
    input  logic           cfg_dyn,
    input  logic           cfg_swap,
    input  logic           cfg_signed,
    input  logic           cfg_sat,
    input  logic [5:0]     cfg_rank,
    input  logic           cfg_co_sel,
    output logic [W-1:0]   z_out,
    output logic           ovf_out,
    output logic           co_out,
    output logic           inv_out
);
    logic [OPW-1:0] code;
    alu_dec_t       dec;
    logic [W-1:0]   opy, opx, lres, z_next;
    logic [W+1:0]   wide;
    logic           c_lo, c_hi, ovf_next;

    assign code = cfg_dyn ? d_op : cfg_op;
    assign opy  = cfg_swap ? x_in : y_in;
    assign opx  = cfg_swap ? y_in : x_in;

    alu_op_decode #(.OPW(OPW)) u_dec (.code(code), .dec(dec));

    alu_core #(.W(W), .CO_LO(CO_LO), .CO_HI(CO_HI)) u_core (
        .dec(dec), .opy(opy), .opx(opx), .cin(cin), .sgn(cfg_signed),
        .wide(wide), .lres(lres), .c_lo(c_lo), .c_hi(c_hi)
    );

    alu_sat #(.W(W), .RW(6)) u_sat (
        .wide(wide), .lres(lres), .valid(dec.valid), .arith(dec.arith),
        .sat_en(cfg_sat), .sgn(cfg_signed), .rank(cfg_rank),
        .z_next(z_next), .ovf_next(ovf_next)
    );

    always_ff @(posedge clk) begin
        if (rst_z)      z_out <= '0;
        else if (wr_en) z_out <= z_next;
    end

    always_ff @(posedge clk) begin
        if (rst_pipe) begin
            ovf_out <= 1'b0;
            co_out  <= 1'b0;
            inv_out <= 1'b0;
        end else if (wr_en) begin
            ovf_out <= ovf_next;
            co_out  <= cfg_co_sel ? c_hi : c_lo;
            inv_out <= ~dec.valid;
        end
    end

    // R3
    inv_zero_chk: assert property (@(posedge clk) disable iff (rst_z)
        inv_out |-> (z_out == '0));
    // R3
    inv_quiet_chk: assert property (@(posedge clk) disable iff (rst_pipe)
        inv_out |-> (!ovf_out && !co_out));
    // R10
    freeze_chk: assert property (@(posedge clk) disable iff (rst_z || rst_pipe)
        !wr_en |=> ($stable(z_out) && $stable(ovf_out) && $stable(co_out) && $stable(inv_out)));
    // R11
    zclr_chk: assert property (@(posedge clk) disable iff (rst_pipe)
        rst_z |=> (z_out == '0));
    // R11
    fclr_chk: assert property (@(posedge clk) disable iff (rst_z)
        rst_pipe |=> (!ovf_out && !co_out && !inv_out));
endmodule

// File: tb/dsp_post_alu_tb.sv
`timescale 1ns/1ps
module dsp_post_alu_tb;
    logic        clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_pipe, rst_z, wr_en, cin, cfg_dyn, cfg_swap, cfg_signed, cfg_sat, cfg_co_sel;
    logic [55:0] y_in, x_in, z_out;
    logic [5:0]  d_op, cfg_op, cfg_rank;
    logic        ovf_out, co_out, inv_out;

    dsp_post_alu u_dut (
        .clk(clk), .rst_pipe(rst_pipe), .rst_z(rst_z), .wr_en(wr_en),
        .y_in(y_in), .x_in(x_in), .cin(cin), .d_op(d_op), .cfg_op(cfg_op),
        .cfg_dyn(cfg_dyn), .cfg_swap(cfg_swap), .cfg_signed(cfg_signed),
        .cfg_sat(cfg_sat), .cfg_rank(cfg_rank), .cfg_co_sel(cfg_co_sel),
        .z_out(z_out), .ovf_out(ovf_out), .co_out(co_out), .inv_out(inv_out)
    );

    localparam logic [5:0] OPS [16] = '{6'b000000, 6'b000001, 6'b001010, 6'b001011,
        6'b000101, 6'b000111, 6'b100000, 6'b110000, 6'b100001, 6'b101001,
        6'b110001, 6'b100010, 6'b101010, 6'b110010, 6'b100011, 6'b110011};

    int          vectors = 0, miscompares = 0;
    bit          finished = 0;
    logic [55:0] ez = '0;
    bit          eovf = 0, eco = 0, einv = 0;

    function automatic longint ext(logic [55:0] v, bit s);
        return s ? longint'({{8{v[55]}}, v}) : longint'({8'b0, v});
    endfunction

    function automatic bit cry(logic [55:0] a, logic [55:0] b, bit c, int k);
        longint unsigned m = (64'd1 << k) - 1;
        longint unsigned s = (a & m) + (b & m) + c;
        return s[k];
    endfunction

    task automatic model(output logic [55:0] zn, output bit ovn, output bit con, output bit ivn);
        logic [5:0]  op = cfg_dyn ? d_op : cfg_op;
        logic [55:0] y  = cfg_swap ? x_in : y_in;
        logic [55:0] x  = cfg_swap ? y_in : x_in;
        longint ye = ext(y, cfg_signed), xe = ext(x, cfg_signed), t = 0, hi, lo;
        logic [55:0] b = '0;
        bit c = 0, ar = 1;
        int r = (cfg_rank > 55) ? 55 : (cfg_rank == 0 ? 1 : int'(cfg_rank));
        zn = '0; ovn = 0; con = 0; ivn = 0;
        case (op)
            6'b000000: begin t = ye + xe;       b = x;  end
            6'b000001: begin t = ye + xe + cin; b = x;  c = cin;  end
            6'b001010: begin t = ye - xe;       b = ~x; c = 1;    end
            6'b001011: begin t = ye - xe - cin; b = ~x; c = !cin; end
            6'b000101: begin t = ye + cin;      c = cin;  end
            6'b000111: begin t = ye - cin;      b = '1; c = !cin; end
            6'b100000: begin ar = 0; zn = y;         end
            6'b110000: begin ar = 0; zn = ~y;        end
            6'b100001: begin ar = 0; zn = y & x;     end
            6'b101001: begin ar = 0; zn = y & ~x;    end
            6'b110001: begin ar = 0; zn = ~(y & x);  end
            6'b100010: begin ar = 0; zn = y | x;     end
            6'b101010: begin ar = 0; zn = y | ~x;    end
            6'b110010: begin ar = 0; zn = ~(y | x);  end
            6'b100011: begin ar = 0; zn = y ^ x;     end
            6'b110011: begin ar = 0; zn = ~(y ^ x);  end
            default:   begin ar = 0; ivn = 1;        end
        endcase
        if (ar) begin
            if (cfg_signed) begin hi = (64'sd1 <<< (r - 1)) - 1; lo = -(64'sd1 <<< (r - 1)); end
            else            begin hi = (64'sd1 <<< r) - 1;       lo = 0; end
            zn  = t[55:0];
            ovn = (t > hi) || (t < lo);
            if (cfg_sat && t > hi) zn = hi[55:0];
            if (cfg_sat && t < lo) zn = lo[55:0];
            con = cry(y, b, c, cfg_co_sel ? 49 : 37);
        end
    endtask

    task automatic tick(string rq);
        logic [55:0] zn; bit ovn, con, ivn;
        model(zn, ovn, con, ivn);
        @(posedge clk);
        if (rst_z) ez = '0; else if (wr_en) ez = zn;
        if (rst_pipe) begin eovf = 0; eco = 0; einv = 0; end
        else if (wr_en) begin eovf = ovn; eco = con; einv = ivn; end
        @(negedge clk);
        vectors++;
        if (z_out !== ez || ovf_out !== eovf || co_out !== eco || inv_out !== einv) begin
            miscompares++;
            $display("FAIL %s: got z=%h ovf=%b co=%b inv=%b, expected z=%h ovf=%b co=%b inv=%b",
                     rq, z_out, ovf_out, co_out, inv_out, ez, eovf, eco, einv);
        end
    endtask

    task automatic run(string rq, logic [5:0] op, logic [55:0] y, logic [55:0] x, logic c);
        cfg_op = op; y_in = y; x_in = x; cin = c;
        tick(rq);
    endtask

    initial begin
        rst_pipe = 1; rst_z = 1; wr_en = 1; cin = 0; cfg_dyn = 0; cfg_swap = 0;
        cfg_signed = 0; cfg_sat = 0; cfg_co_sel = 0; y_in = 56'h12345; x_in = 56'h777;
        d_op = 6'b111111; cfg_op = 6'b111111; cfg_rank = 6'd55;
        tick("R12"); tick("R12");
        rst_pipe = 0; rst_z = 0;
        // R1 arithmetic set, signed and unsigned
        run("R1", 6'b000000, 56'd1000, 56'd234, 0);
        run("R1", 6'b000001, 56'd1000, 56'd234, 1);
        run("R1", 6'b001010, 56'd1000, 56'd234, 0);
        run("R1", 6'b001011, 56'd1000, 56'd234, 1);
        run("R1", 6'b000101, 56'd41, 56'd9, 1);
        run("R1", 6'b000111, 56'd41, 56'd9, 1);
        cfg_signed = 1;
        run("R1", 6'b001010, 56'd5, 56'd9, 0);
        run("R1", 6'b000111, 56'd0, 56'd9, 1);
        cfg_signed = 0;
        // R2 bitwise set
        foreach (OPS[i]) if (i >= 6) run("R2", OPS[i], 56'hF0F0_1234_5678_9A, 56'h0FF0_FFFF_0000_11, 1);
        // R3 invalid codes
        run("R3", 6'b000010, 56'hFF, 56'h1, 1);
        run("R3", 6'b111111, 56'hFF, 56'h1, 1);
        run("R3", 6'b010000, 56'hFF, 56'h1, 1);
        // R4 swap
        cfg_swap = 1;
        run("R4", 6'b001010, 56'd3, 56'd100, 0);
        run("R4", 6'b110000, 56'd3, 56'd100, 0);
        cfg_swap = 0;
        // R5 dynamic source
        cfg_dyn = 1; d_op = 6'b001010;
        run("R5", 6'b000000, 56'd50, 56'd8, 0);
        d_op = 6'b011111;
        run("R5", 6'b000000, 56'd50, 56'd8, 0);
        cfg_dyn = 0; d_op = 6'b001010;
        run("R5", 6'b000000, 56'd50, 56'd8, 0);
        // R6 carry taps
        run("R6", 6'b000000, (56'd1 << 37) - 1, 56'd1, 0);
        cfg_co_sel = 1;
        run("R6", 6'b000000, (56'd1 << 37) - 1, 56'd1, 0);
        run("R6", 6'b000000, (56'd1 << 49) - 1, 56'd1, 0);
        run("R6", 6'b001010, 56'd9, 56'd4, 0);
        cfg_co_sel = 0;
        // R7 R8 R9 rank, clamping, wrap
        cfg_rank = 6'd32; cfg_signed = 1; cfg_sat = 1;
        run("R8", 6'b000000, 56'h7FFF_FFFF, 56'd1, 0);
        run("R8", 6'b001010, 56'hFF_FFFF_8000_0000, 56'd1, 0);
        run("R7", 6'b000000, 56'h7FFF_FFFE, 56'd1, 0);
        cfg_signed = 0;
        run("R8", 6'b001010, 56'd0, 56'd1, 0);
        run("R8", 6'b000001, 56'hFFFF_FFFF, 56'd0, 1);
        cfg_sat = 0;
        run("R9", 6'b000001, 56'hFFFF_FFFF, 56'd0, 1);
        cfg_rank = 6'd60;
        run("R7", 6'b000000, 56'h80_0000_0000_0000, 56'd0, 0);
        cfg_rank = 6'd0; cfg_signed = 1; cfg_sat = 1;
        run("R7", 6'b000000, 56'd1, 56'd0, 0);
        cfg_sat = 0; cfg_rank = 6'd55; cfg_signed = 0;
        // R10 freeze
        run("R10", 6'b000000, 56'd7, 56'd7, 0);
        wr_en = 0;
        run("R10", 6'b111111, 56'd1, 56'd99, 1);
        run("R10", 6'b001010, 56'd0, 56'd99, 1);
        wr_en = 1;
        // R11 separate resets with write enable low
        run("R11", 6'b001010, 56'd0, 56'd1, 0);
        wr_en = 0; rst_z = 1;
        run("R11", 6'b001010, 56'd0, 56'd1, 0);
        rst_z = 0; wr_en = 1;
        run("R11", 6'b000101, 56'h3F_FFFF_FFFF_FFFF, 56'd0, 1);
        wr_en = 0; rst_pipe = 1;
        tick("R11");
        rst_pipe = 0; wr_en = 1;
        // mixed random vectors
        for (int n = 0; n < 600; n++) begin
            cfg_op     = ($urandom % 8 == 0) ? 6'($urandom) : OPS[$urandom % 16];
            d_op       = ($urandom % 8 == 0) ? 6'($urandom) : OPS[$urandom % 16];
            y_in       = {24'($urandom), 32'($urandom)};
            x_in       = ($urandom % 2) ? {24'($urandom), 32'($urandom)} : 56'($urandom % 64);
            cin        = 1'($urandom); cfg_dyn = 1'($urandom); cfg_swap = 1'($urandom);
            cfg_signed = 1'($urandom); cfg_sat = 1'($urandom); cfg_co_sel = 1'($urandom);
            cfg_rank   = 6'($urandom);
            wr_en      = ($urandom % 8) != 0;
            rst_z      = ($urandom % 16) == 0;
            rst_pipe   = ($urandom % 16) == 0;
            tick("R7");
        end
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule